// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fetch Memory

This block is the memory side of a cache refill path. It holds a cache block of four 32-bit words spread across four one-word-wide banks. Word k of every block lives in bank k, at a row index equal to the block address. The cache presents one block address. In the overlapped mode, all four banks begin their access together once the address cycle is over. When the shared 15-cycle access time has passed, the four words come back over a single 32-bit path, one word per cycle, in ascending order. A data-valid strobe marks each word, and a done pulse marks the final one.

A comparison mode runs the same fetch through one bank at a time. Each word then waits out its own full access before its transfer. A block write gathers four words over the narrow path into per-lane holding registers, then commits all four banks in one overlapped access. Only one request is in flight at any time, and a ready output shows when the next one can be taken. The banks are cycle-accurate models: plain arrays with a fixed access latency.

Top module: `ilv_block_mem`

## Requirements
- R1: After reset, ready is 1, and rd_valid and done are both 0.
- R2: A read is accepted in the cycle where req_valid is 1, ready is 1 and req_write is 0; call that cycle 1. With mode_single at 0 in cycle 1, rd_valid is 1 in cycles 17 to 20 only, carrying word 0, 1, 2, 3 in that order.
- R3: Word k returned for block address A is the word that the most recent block write to A supplied as its k-th data word.
- R4: done is 1 in the cycle that carries the fourth word, and in no other cycle.
- R5: ready is 0 from cycle 2 until the transaction ends, and is 1 again in the following cycle (cycle 21 for an overlapped read or any write, cycle 66 for a one-bank read). A request presented while ready is 0 is not accepted and changes no stored word.
- R6: With mode_single at 1 in cycle 1, a read returns word k in cycle 17+16k, so words arrive in cycles 17, 33, 49 and 65, and rd_valid is 0 in all other cycles.
- R7: A write is accepted like a read but with req_write at 1. wr_data is sampled in cycles 2, 3, 4 and 5 as words 0 to 3, whatever the value of mode_single.
- R8: A write never raises rd_valid or done.
- R9: mode_single is sampled only in the acceptance cycle; changing it later does not alter the timing of the transaction in progress.
- R10: A bank never receives a new access while its current access is still in progress, and all four banks finish an overlapped access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 selects a block write, 0 a block read |
| mode_single | input | 1 | 1 selects one-bank-at-a-time reads |
| req_addr | input | AW (6) | Block address (bank row index) |
| wr_data | input | DW (32) | Write word, one per cycle in cycles 2 to 5 of a write |
| ready | output | 1 | Controller idle, request can be taken |
| rd_valid | output | 1 | rd_data carries a block word |
| rd_data | output | DW (32) | Returned block word |
| done | output | 1 | Pulses with the last word of a read |

## Verification
If a bank counter or the word index goes wrong, the fault shows at the ports in the first cycle where a word is due. A strobe arrives a cycle early or late, or it has a missing word or an extra one, or a word comes out in the wrong order. A lane that is not aligned with the others in overlapped mode shows as a stretch of wrong data in cycles 17 to 20. A bad capture in the write holding registers stays hidden until that block is read back, and then shows as a wrong word in one lane. A controller stuck in a busy state keeps ready low after cycle 21, or after cycle 66 for a one-bank read. A request wrongly accepted while busy shows as a corrupted word when the block is read later.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_WLOAD,
    ST_WBUSY
  } ilv_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DW  = 32,
  parameter int AW  = 6,
  parameter int LAT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          fin,
  output logic [DW-1:0] rdata
);
  localparam int CW    = $clog2(LAT + 1);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  // the access finishes on the edge that ends the LAT-th busy cycle
  assign fin   = busy_q && (cnt_q == CW'(1));
  assign rdata = rdata_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT);
    end else if (busy_q) begin
      if (fin) busy_d = 1'b0;
      else     cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // command capture, enabled by start
  always_ff @(posedge clk) begin
    if (start) begin
      we_q    <= we;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (fin && we_q) mem[addr_q] <= wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdata_q <= '0;
    else if (fin && !we_q)  rdata_q <= mem[addr_q];
  end

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int NW = 4,
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   mode_single,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NW-1:0]          fin,
  output logic                   ready,
  output logic                   rd_valid,
  output logic                   done,
  output logic [$clog2(NW)-1:0]  sel,
  output logic [NW-1:0]          bank_start,
  output logic                   bank_we,
  output logic [AW-1:0]          bank_addr,
  output logic [NW-1:0][DW-1:0]  bank_wdata
);
  localparam int IW = $clog2(NW);

  ilv_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          single_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wlat_q [NW-1];
  logic          accept, last;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign last   = (idx_q == IW'(NW - 1));

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    bank_start = '0;
    bank_we    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (accept) begin
          if (req_write) begin
            state_d = ST_WLOAD;
          end else begin
            state_d    = ST_WAIT;
            bank_start = mode_single ? NW'(1) : '1;
          end
        end
      end
      ST_WAIT: begin
        if (single_q ? fin[idx_q] : &fin) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (last) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IW'(1);
          if (single_q) begin
            state_d    = ST_WAIT;
            bank_start = NW'(1) << idx_d;
          end
        end
      end
      ST_WLOAD: begin
        if (last) begin
          state_d    = ST_WBUSY;
          idx_d      = '0;
          bank_start = '1;
          bank_we    = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      ST_WBUSY: begin
        if (&fin) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      single_q <= mode_single;
      addr_q   <= req_addr;
    end
  end

  // holding registers for all lanes but the last; the last lane word
  // is handed straight to its bank in the commit cycle
  for (genvar g = 0; g < NW; g++) begin : g_lane
    if (g == NW - 1) begin : g_pass
      assign bank_wdata[g] = wr_data;
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (state_q == ST_WLOAD && idx_q == IW'(g)) wlat_q[g] <= wr_data;
      end
      assign bank_wdata[g] = wlat_q[g];
    end
  end

  assign bank_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign ready     = (state_q == ST_IDLE);
  assign rd_valid  = (state_q == ST_XFER);
  assign done      = (state_q == ST_XFER) && last;
  assign sel       = idx_q;

  // R4
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);
  // R10
  lanes_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !single_q && |fin) |-> &fin);
  // R10
  fin_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |fin |-> (state_q == ST_WAIT || state_q == ST_WBUSY));
  // R6
  single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && single_q && !done) |=> !rd_valid);
endmodule

// File: rtl/ilv_block_mem.sv
module ilv_block_mem #(
  parameter int DW  = 32,
  parameter int AW  = 6,
  parameter int NW  = 4,
  parameter int LAT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          mode_single,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] wr_data,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  localparam int IW = $clog2(NW);

  logic                  rst_meta, rst_sync;
  logic [NW-1:0]         fin;
  logic [NW-1:0]         bank_start;
  logic                  bank_we;
  logic [AW-1:0]         bank_addr;
  logic [NW-1:0][DW-1:0] bank_wdata;
  logic [NW-1:0][DW-1:0] bank_rdata;
  logic [IW-1:0]         sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ilv_seq #(.NW(NW), .AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .mode_single(mode_single),
    .req_addr   (req_addr),
    .wr_data    (wr_data),
    .fin        (fin),
    .ready      (ready),
    .rd_valid   (rd_valid),
    .done       (done),
    .sel        (sel),
    .bank_start (bank_start),
    .bank_we    (bank_we),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata)
  );

  for (genvar b = 0; b < NW; b++) begin : g_bank
    ilv_bank #(.DW(DW), .AW(AW), .LAT(LAT)) u_bank (
      .clk  (clk),
      .rst_n(rst_sync),
      .start(bank_start[b]),
      .we   (bank_we),
      .addr (bank_addr),
      .wdata(bank_wdata[b]),
      .fin  (fin[b]),
      .rdata(bank_rdata[b])
    );
  end

  assign rd_data = bank_rdata[sel];
endmodule

// File: tb/ilv_block_mem_tb.sv
module ilv_block_mem_tb;
  localparam int CLK_P = 10;
  localparam int NW    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, mode_single;
  logic [5:0]  req_addr;
  logic [31:0] wr_data;
  logic        ready, rd_valid, done;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [31:0] model [NW][64];

  always #(CLK_P/2) clk = ~clk;

  ilv_block_mem u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .mode_single(mode_single), .req_addr(req_addr), .wr_data(wr_data),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wword(input int a, input int k, input int seed);
    return 32'(seed) + 32'(k) * 32'h1111_1111 + 32'(a);
  endfunction

  // block write; the mode input is driven to ms to show it is ignored (R7)
  task automatic do_write(input int a, input int seed, input bit ms);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); mode_single = ms;
    @(posedge clk);
    for (int c = 2; c <= 21; c++) begin
      @(negedge clk);
      chk(rd_valid == 1'b0, "R8 write rd_valid", 32'(rd_valid), 0);
      chk(done == 1'b0, "R8 write done", 32'(done), 0);
      chk(ready == (c == 21), "R7 write ready", 32'(ready), 32'(c == 21));
      if (c == 2) req_valid = 1'b0;
      if (c >= 2 && c <= 5) wr_data = wword(a, c - 2, seed);
    end
    for (int k = 0; k < NW; k++) model[k][a] = wword(a, k, seed);
    mode_single = 1'b0;
  endtask

  // block read; flip changes the mode input after acceptance (R9),
  // junk presents a write request while busy (R5)
  task automatic do_read(input int a, input bit s, input bit flip,
                         input bit junk, input int jaddr);
    int last;
    bit ev;
    int k;
    last = s ? 17 + 16 * (NW - 1) : 17 + NW - 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a); mode_single = s;
    @(posedge clk);
    for (int c = 2; c <= last + 1; c++) begin
      @(negedge clk);
      if (s) begin
        ev = (c >= 17) && (c <= last) && ((c - 17) % 16 == 0);
        k  = (c - 17) / 16;
      end else begin
        ev = (c >= 17) && (c <= last);
        k  = c - 17;
      end
      chk(rd_valid == ev, s ? "R6 rd_valid timing" : "R2 rd_valid timing",
          32'(rd_valid), 32'(ev));
      if (ev)
        chk(rd_data == model[k][a], "R3 word data", rd_data, model[k][a]);
      chk(done == (c == last), "R4 done", 32'(done), 32'(c == last));
      chk(ready == (c == last + 1), "R5 ready", 32'(ready), 32'(c == last + 1));
      if (c == 2) begin
        req_valid = 1'b0;
        if (flip) mode_single = ~s;
      end
      if (junk && c == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(jaddr);
        wr_data = 32'hDEAD_0000;
      end
      if (junk && c == 11) begin
        req_valid = 1'b0; req_write = 1'b0;
      end
    end
    mode_single = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; mode_single = 1'b0;
    req_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready == 1'b1, "R1 reset ready", 32'(ready), 1);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", 32'(rd_valid), 0);
    chk(done == 1'b0, "R1 reset done", 32'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    do_write(5, 32'h0A00_0100, 1'b0);   // R7
    do_write(6, 32'h0B30_0007, 1'b1);   // R7 mode input ignored on writes
    do_write(63, 32'h7F00_0C00, 1'b0);  // R7 top address
    do_write(0, 32'h0000_5A5A, 1'b0);
    do_read(5, 1'b0, 1'b0, 1'b0, 0);    // R2 R3 R4 R5
    do_read(6, 1'b1, 1'b0, 1'b0, 0);    // R6
    do_read(63, 1'b0, 1'b1, 1'b0, 0);   // R9 overlapped read, mode flipped
    do_read(0, 1'b1, 1'b1, 1'b1, 5);    // R9 one-bank read, R5 busy request
    do_read(5, 1'b0, 1'b0, 1'b0, 0);    // R5 block 5 untouched by busy request
    do_write(5, 32'h1234_0000, 1'b0);   // R3 overwrite
    do_read(5, 1'b1, 1'b0, 1'b0, 0);    // R3 new contents
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule